// File: doc/BRIEF.md
# Link Transmit Command Queue

This block sits in front of a point-to-point chip-to-chip link and turns non-blocking send commands into link packets. A caller posts a command carrying a source word address, a destination word address and a length. Addresses and lengths all count 16-byte words, so byte offsets below 16 never appear. The command lands in one of two independent queues and is served later. The submitter gets no completion report and must poll a per-queue busy flag before posting.

A segmenter takes the head command of a queue and emits one or more packets on a valid/ready streaming port. Each packet starts with a header word that gives the destination word address, the payload length and the queue number. Payload words then follow, read from a local memory port with a combinational read path. A command longer than the largest packet is cut into consecutive packets. Commands within a queue complete in posting order. Between the two queues, the engine alternates at packet boundaries and imposes no order. Queue 1 is held back for later use until a configuration input enables it.

Top module: `link_txq`

## Requirements
- R1: A submit (`sub_valid_i` high at a clock edge) is accepted when the selected queue is enabled, `busy_o` for that queue is low and the length is nonzero; the command is then transmitted without any further action from the submitter.
- R2: Every packet begins with one header word: bits [15:0] hold the payload length in words, bits [43:16] the destination word address, bit 44 the queue number, all higher bits zero.
- R3: A command of L words is sent as packets of min(remaining, 93) words (93 words is the largest payload within 1500 bytes); each packet's destination is the command destination plus the words already sent, and payload word i of a packet is the memory word at the packet's source address plus i.
- R4: Packets of one queue leave in command posting order, and all packets of a command leave before any packet of the next command of that queue.
- R5: When both queues hold work, packet grants alternate between the queues; a switch happens only after the last payload word of a packet.
- R6: Each queue holds 4 commands; `busy_o[q]` is high while queue q holds 4 commands.
- R7: `busy_o[q]` is also high while a packet of queue q is offered on the transmit port and `tx_ready_i` is low; the other queue's busy flag is not affected.
- R8: While `q1_enable_i` is low, `busy_o[1]` is high and submits to queue 1 are dropped and produce no packet.
- R9: A submit with zero length, or to a queue whose busy flag is high, is dropped and sets `err_o`, which stays high until reset.
- R10: While `tx_valid_o` is high and `tx_ready_i` low, the offered word and `tx_last_o` hold; `tx_last_o` is high exactly on the final payload word of each packet.
- R11: After reset, `tx_valid_o` and `err_o` are low, `busy_o[0]` is low and `busy_o[1]` follows R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| q1_enable_i | input | 1 | Enables the reserved queue 1 |
| sub_valid_i | input | 1 | Submit strobe |
| sub_queue_i | input | 1 | Target queue of the submit |
| sub_src_i | input | 28 | Source word address |
| sub_dst_i | input | 28 | Destination word address |
| sub_len_i | input | 16 | Length in words |
| busy_o | output | 2 | Per-queue busy flag |
| err_o | output | 1 | Sticky dropped-submit flag |
| mem_rd_o | output | 1 | Memory read active |
| mem_addr_o | output | 28 | Memory word address |
| mem_rdata_i | input | 128 | Memory read data, same cycle |
| tx_valid_o | output | 1 | Transmit word valid |
| tx_ready_i | input | 1 | Transmit word accepted |
| tx_data_o | output | 128 | Header or payload word |
| tx_last_o | output | 1 | Final payload word of a packet |

## Verification
The bench sends lengths of exactly 93, 94 and 200 words. A segmenter with an off-by-one boundary would emit a zero-length or 94-word packet, or send the wrong destination for a later piece. It keeps both queues loaded under stuttering back-pressure and checks the order of queue numbers in the headers. A wrong arbiter would repeat a queue or switch inside a packet, and the payload check would then fail. It posts zero-length commands, commands to the disabled queue and commands to a full queue. A design that let any of them through would emit a packet the scoreboard does not expect, and one that forgot the sticky error would clear `err_o`. With the port stalled, it checks that only the stalled queue reports busy.

// File: rtl/link_txq_pkg.sv
package link_txq_pkg;
  localparam int NQ    = 2;
  localparam int QID_W = 1;
  typedef enum logic [1:0] {SG_IDLE, SG_HDR, SG_PAY} seg_state_e;
endpackage

// File: rtl/link_txq_fifo.sv
module link_txq_fifo #(
  parameter int W     = 72,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= data_i;
  end

  assign head_o  = mem_q[rp_q];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/link_txq_arb.sv
module link_txq_arb #(
  parameter int NQ = 2,
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NQ-1:0] req_i,
  input  logic          adv_i,
  output logic [NQ-1:0] gnt_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic [IW-1:0] last_q;
  logic          found;

  always_comb begin
    found     = 1'b0;
    gnt_idx_o = '0;
    for (int k = 1; k <= NQ; k++) begin
      int j;
      j = (int'(last_q) + k) % NQ;
      if (!found && req_i[j]) begin
        found     = 1'b1;
        gnt_idx_o = IW'(j);
      end
    end
    gnt_o = found ? (NQ'(1) << gnt_idx_o) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= IW'(NQ - 1);
    else if (adv_i) last_q <= gnt_idx_o;
  end

  assert_gnt_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_gnt_when_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|(gnt_o & req_i)));
endmodule

// File: rtl/link_txq_seg.sv
module link_txq_seg
  import link_txq_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int LEN_W   = 16,
  parameter int DATA_W  = 128,
  parameter int MAX_PKT = 93,
  parameter int NQ      = 2,
  localparam int IW     = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NQ-1:0]                q_empty_i,
  input  logic [NQ-1:0][ADDR_W-1:0]    head_src_i,
  input  logic [NQ-1:0][ADDR_W-1:0]    head_dst_i,
  input  logic [NQ-1:0][LEN_W-1:0]     head_len_i,
  output logic [NQ-1:0]                pop_o,
  output logic [NQ-1:0]                stall_o,
  output logic                         mem_rd_o,
  output logic [ADDR_W-1:0]            mem_addr_o,
  input  logic [DATA_W-1:0]            mem_rdata_i,
  output logic                         tx_valid_o,
  input  logic                         tx_ready_i,
  output logic [DATA_W-1:0]            tx_data_o,
  output logic                         tx_last_o
);
  localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_PKT);

  seg_state_e                  state_q;
  logic [IW-1:0]               cur_q;
  logic [ADDR_W-1:0]           psrc_q, pdst_q;
  logic [LEN_W-1:0]            plen_q, beat_q;
  logic [NQ-1:0][LEN_W-1:0]    off_q;

  logic [NQ-1:0]   gnt;
  logic [IW-1:0]   gidx;
  logic            adv;
  logic [LEN_W-1:0] rem_g, plen_n, new_off;

  link_txq_arb #(.NQ(NQ)) u_arb (
    .clk_i, .rst_ni,
    .req_i    (~q_empty_i),
    .adv_i    (adv),
    .gnt_o    (gnt),
    .gnt_idx_o(gidx)
  );

  assign adv     = (state_q == SG_IDLE) && (|gnt);
  assign rem_g   = head_len_i[gidx] - off_q[gidx];
  assign plen_n  = (rem_g > MAXL) ? MAXL : rem_g;
  assign new_off = off_q[cur_q] + plen_q;

  assign tx_valid_o = (state_q != SG_IDLE);
  assign tx_last_o  = (state_q == SG_PAY) && (beat_q == plen_q - 1'b1);
  assign mem_rd_o   = (state_q == SG_PAY);
  assign mem_addr_o = psrc_q + ADDR_W'(beat_q);

  always_comb begin
    tx_data_o = '0;
    if (state_q == SG_PAY) begin
      tx_data_o = mem_rdata_i;
    end else begin
      tx_data_o[LEN_W-1:0]            = plen_q;
      tx_data_o[LEN_W +: ADDR_W]      = pdst_q;
      tx_data_o[LEN_W + ADDR_W +: IW] = cur_q;
    end
  end

  always_comb begin
    pop_o   = '0;
    stall_o = '0;
    if (tx_valid_o && !tx_ready_i) stall_o[cur_q] = 1'b1;
    if (state_q == SG_PAY && tx_ready_i && tx_last_o && new_off == head_len_i[cur_q])
      pop_o[cur_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SG_IDLE;
      cur_q   <= '0;
      psrc_q  <= '0;
      pdst_q  <= '0;
      plen_q  <= '0;
      beat_q  <= '0;
      off_q   <= '0;
    end else begin
      unique case (state_q)
        SG_IDLE: if (adv) begin
          cur_q   <= gidx;
          plen_q  <= plen_n;
          psrc_q  <= head_src_i[gidx] + ADDR_W'(off_q[gidx]);
          pdst_q  <= head_dst_i[gidx] + ADDR_W'(off_q[gidx]);
          state_q <= SG_HDR;
        end
        SG_HDR: if (tx_ready_i) begin
          beat_q  <= '0;
          state_q <= SG_PAY;
        end
        SG_PAY: if (tx_ready_i) begin
          if (tx_last_o) begin
            off_q[cur_q] <= (new_off == head_len_i[cur_q]) ? '0 : new_off;
            state_q      <= SG_IDLE;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        default: state_q <= SG_IDLE;
      endcase
    end
  end

  assert_pkt_len_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (plen_q != '0 && plen_q <= MAXL));
  assert_offset_inside_cmd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_empty_i[cur_q] |-> (off_q[cur_q] < head_len_i[cur_q]));
  assert_hold_under_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(mem_addr_o) &&
                                     $stable(tx_last_o) && $stable(state_q)));
endmodule

// File: rtl/link_txq.sv
module link_txq
  import link_txq_pkg::*;
#(
  parameter int ADDR_W        = 28,
  parameter int LEN_W         = 16,
  parameter int DATA_W        = 128,
  parameter int QDEPTH        = 4,
  parameter int MAX_PKT_WORDS = 93
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              q1_enable_i,
  input  logic              sub_valid_i,
  input  logic [QID_W-1:0]  sub_queue_i,
  input  logic [ADDR_W-1:0] sub_src_i,
  input  logic [ADDR_W-1:0] sub_dst_i,
  input  logic [LEN_W-1:0]  sub_len_i,
  output logic [NQ-1:0]     busy_o,
  output logic              err_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_last_o
);
  localparam int CMD_W = 2 * ADDR_W + LEN_W;

  logic [NQ-1:0]              q_full, q_empty, q_stall, q_en, push, pop;
  logic [NQ-1:0][CMD_W-1:0]   cmd_head;
  logic [NQ-1:0][ADDR_W-1:0]  head_src, head_dst;
  logic [NQ-1:0][LEN_W-1:0]   head_len;
  logic [CMD_W-1:0]           cmd_in;
  logic                       drop, err_q;

  assign cmd_in = {sub_src_i, sub_dst_i, sub_len_i};

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign q_en[q]   = (q == 0) ? 1'b1 : q1_enable_i;
    assign busy_o[q] = q_full[q] | q_stall[q] | ~q_en[q];
    assign push[q]   = sub_valid_i && (sub_queue_i == QID_W'(q)) &&
                       !busy_o[q] && (sub_len_i != '0);

    link_txq_fifo #(.W(CMD_W), .DEPTH(QDEPTH)) u_fifo (
      .clk_i, .rst_ni,
      .push_i (push[q]),
      .data_i (cmd_in),
      .pop_i  (pop[q]),
      .head_o (cmd_head[q]),
      .full_o (q_full[q]),
      .empty_o(q_empty[q])
    );

    assign head_src[q] = cmd_head[q][CMD_W-1 -: ADDR_W];
    assign head_dst[q] = cmd_head[q][LEN_W +: ADDR_W];
    assign head_len[q] = cmd_head[q][LEN_W-1:0];
  end

  link_txq_seg #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
    .MAX_PKT(MAX_PKT_WORDS), .NQ(NQ)
  ) u_seg (
    .clk_i, .rst_ni,
    .q_empty_i  (q_empty),
    .head_src_i (head_src),
    .head_dst_i (head_dst),
    .head_len_i (head_len),
    .pop_o      (pop),
    .stall_o    (q_stall),
    .mem_rd_o,
    .mem_addr_o,
    .mem_rdata_i,
    .tx_valid_o,
    .tx_ready_i,
    .tx_data_o,
    .tx_last_o
  );

  assign drop = sub_valid_i && (busy_o[sub_queue_i] || sub_len_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   err_q <= 1'b0;
    else if (drop) err_q <= 1'b1;
  end
  assign err_o = err_q;

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_zero_len_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_valid_i && sub_len_i == '0) |=> err_o);
  assert_q1_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q1_enable_i && sub_valid_i && sub_queue_i == QID_W'(1)) |=> err_o);
endmodule

// File: tb/link_txq_tb_top.sv
module link_txq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 28, LW = 16, DW = 128, MAXW = 93;

  typedef struct {int q; int dst; int len; int src;} pkt_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic q1_enable_i = 1'b0, sub_valid_i = 1'b0, sub_queue_i = 1'b0;
  logic [AW-1:0] sub_src_i = '0, sub_dst_i = '0, mem_addr_o;
  logic [LW-1:0] sub_len_i = '0;
  logic [1:0] busy_o;
  logic err_o, mem_rd_o, tx_valid_o, tx_last_o;
  logic tx_ready_i = 1'b0;
  logic [DW-1:0] mem_rdata_i, tx_data_o;

  int checks = 0, errors = 0, cyc = 0, rdy_mode = 0, hdr_count = 0;
  pkt_t exp_q0[$], exp_q1[$];
  int hdr_log[$];
  bit in_pkt = 0;
  pkt_t cur;
  int beat = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_txq dut_i (
    .clk_i(clk), .rst_ni, .q1_enable_i, .sub_valid_i, .sub_queue_i,
    .sub_src_i, .sub_dst_i, .sub_len_i, .busy_o, .err_o, .mem_rd_o,
    .mem_addr_o, .mem_rdata_i, .tx_valid_o, .tx_ready_i, .tx_data_o, .tx_last_o
  );

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return {4'h1, a, 4'h2, a ^ 28'hABCDEF1, 4'h3, a + 28'd7, 4'h4, ~a};
  endfunction

  function automatic logic [DW-1:0] hdr(input pkt_t p);
    logic [DW-1:0] h;
    h = '0;
    h[15:0]  = LW'(p.len);
    h[43:16] = AW'(p.dst);
    h[44]    = p.q[0];
    return h;
  endfunction

  assign mem_rdata_i = memf(mem_addr_o);

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // ready pattern registered at the clock edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    case (rdy_mode)
      0:       tx_ready_i <= 1'b1;
      1:       tx_ready_i <= 1'b0;
      default: tx_ready_i <= (cyc % 3) != 0;
    endcase
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && tx_valid_o && tx_ready_i) begin
      if (!in_pkt) begin
        int q;
        bit have;
        q = int'(tx_data_o[44]);
        have = (q == 0) ? (exp_q0.size() > 0) : (exp_q1.size() > 0);
        hdr_count++;
        hdr_log.push_back(q);
        if (!have) begin
          check(0, "R4 unexpected packet", tx_data_o, '0);
        end else begin
          cur = (q == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
          check(tx_data_o == hdr(cur), "R2/R3 header", tx_data_o, hdr(cur));
          check(!tx_last_o, "R10 last on header", DW'(tx_last_o), '0);
          in_pkt = 1;
          beat = 0;
        end
      end else begin
        logic [DW-1:0] e;
        e = memf(AW'(cur.src + beat));
        check(tx_data_o == e, "R3 payload", tx_data_o, e);
        check(tx_last_o == (beat == cur.len - 1), "R10 last flag",
              DW'(tx_last_o), DW'(beat == cur.len - 1));
        beat++;
        if (beat == cur.len) in_pkt = 0;
      end
    end
  end

  task automatic add_exp(input int q, input int src, input int dst, input int len);
    int off = 0;
    while (off < len) begin
      pkt_t p;
      p.q   = q;
      p.len = (len - off > MAXW) ? MAXW : len - off;
      p.dst = dst + off;
      p.src = src + off;
      if (q == 0) exp_q0.push_back(p); else exp_q1.push_back(p);
      off += p.len;
    end
  endtask

  task automatic drive(input int q, input int src, input int dst, input int len);
    sub_valid_i = 1'b1;
    sub_queue_i = q[0];
    sub_src_i   = AW'(src);
    sub_dst_i   = AW'(dst);
    sub_len_i   = LW'(len);
    @(negedge clk);
    sub_valid_i = 1'b0;
  endtask

  task automatic submit(input int q, input int src, input int dst, input int len);
    @(negedge clk);
    while (busy_o[q]) @(negedge clk);
    add_exp(q, src, dst, len);
    drive(q, src, dst, len);
  endtask

  task automatic force_submit(input int q, input int src, input int dst, input int len);
    @(negedge clk);
    drive(q, src, dst, len);
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_q0.size() != 0 || exp_q1.size() != 0 || in_pkt) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int h0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(tx_valid_o == 1'b0, "R11 tx_valid", DW'(tx_valid_o), '0);
    check(err_o == 1'b0, "R11 err", DW'(err_o), '0);
    check(busy_o == 2'b10, "R11 busy", DW'(busy_o), DW'(2'b10));
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 single short command
    rdy_mode = 0;
    submit(0, 100, 'h2000, 5);
    drain();
    check(hdr_count == 1, "R1 one packet", DW'(hdr_count), DW'(1));

    // R3 segmentation boundaries under stuttering ready
    rdy_mode = 2;
    submit(0, 'h300, 'h4000, 93);
    submit(0, 'h500, 'h5000, 94);
    submit(0, 'h700, 'h6000, 200);
    drain();
    check(hdr_count == 1 + 1 + 2 + 3, "R3 packet count", DW'(hdr_count), DW'(7));

    // R9 zero length dropped, sticky error
    check(err_o == 1'b0, "R9 err before drop", DW'(err_o), '0);
    h0 = hdr_count;
    force_submit(0, 'h10, 'h20, 0);
    check(err_o == 1'b1, "R9 err after zero length", DW'(err_o), DW'(1));
    repeat (20) @(negedge clk);
    check(hdr_count == h0 && !tx_valid_o, "R9 zero length emits nothing",
          DW'(hdr_count), DW'(h0));

    // R8 queue 1 disabled
    check(busy_o[1] == 1'b1, "R8 q1 busy while disabled", DW'(busy_o[1]), DW'(1));
    force_submit(1, 'h40, 'h50, 8);
    repeat (20) @(negedge clk);
    check(hdr_count == h0 && !tx_valid_o, "R8 q1 submit ignored",
          DW'(hdr_count), DW'(h0));

    // R7 stall makes only the served queue busy
    q1_enable_i = 1'b1;
    rdy_mode = 1;
    submit(0, 'h900, 'h7000, 3);
    repeat (4) @(negedge clk);
    check(busy_o[0] == 1'b1, "R7 stalled queue busy", DW'(busy_o[0]), DW'(1));
    check(busy_o[1] == 1'b0, "R7 other queue free", DW'(busy_o[1]), '0);
    rdy_mode = 0;
    drain();
    check(busy_o == 2'b00, "R7 busy clears", DW'(busy_o), '0);

    // R6 full queue
    for (int i = 0; i < 4; i++) submit(0, 'hA00 + i * 64, 'h8000 + i * 64, 60);
    @(negedge clk);
    check(busy_o[0] == 1'b1, "R6 busy when full", DW'(busy_o[0]), DW'(1));
    force_submit(0, 'hF00, 'hF000, 4);
    drain();
    check(err_o == 1'b1, "R9 err sticky", DW'(err_o), DW'(1));

    // R4 R5 both queues loaded
    rdy_mode = 2;
    hdr_log.delete();
    submit(0, 'h1000, 'h10000, 200);
    submit(1, 'h2000, 'h20000, 150);
    submit(0, 'h3000, 'h30000, 10);
    submit(1, 'h4000, 'h40000, 20);
    drain();
    check(hdr_log.size() == 7, "R5 packet count", DW'(hdr_log.size()), DW'(7));
    for (int i = 0; i < hdr_log.size(); i++)
      check(hdr_log[i] == (i % 2), "R5 alternation", DW'(hdr_log[i]), DW'(i % 2));
    check(err_o == 1'b1, "R9 err still set", DW'(err_o), DW'(1));
    summary();
  end
endmodule